// File: doc/BRIEF.md
# CPU Address Router with Scratchpad Overlay

This block takes the single memory port of a small CPU (valid, ready, byte address, write data, byte strobes, read data) and steers each request to exactly one target: an on-chip scratchpad SRAM that it contains, the external flash read controller, three word-wide control registers (flash configuration, UART baud divider, UART data), or an external user-peripheral port. The selected target's ready and read data are returned to the CPU. The CPU holds its request stable until it sees ready.

The lowest 16 MB window belongs to the scratchpad. The physical SRAM covers only its first few words. A read that lands past the end of the physical SRAM is passed to flash at the same 24-bit offset, so the CPU can boot from offset 0x00100000 of flash even though that address lies inside the scratchpad window. Writes that no target can store are acknowledged at once and dropped. Unassigned words in the register window answer at once with zero, so a stray access cannot stall the CPU.

Top module: `soc_addr_router`

## Requirements
- R1: The top address byte selects the region: 0x00 goes to the scratchpad window, 0x01 to the flash window, 0x02 to the register window, and 0x03 to 0xFF to the user port (usr_valid, usr_addr equal to the full address). At most one of the target selects is active in any cycle.
- R2: A scratchpad access whose word index is below SRAM_WORDS is acknowledged in the cycle after the request is presented. A read returns the word last written at that index.
- R3: On a scratchpad write, strobe bit i writes byte i (data bits 8i+7..8i) only. Bytes whose strobe is 0 keep their old value.
- R4: A read in the scratchpad window at or beyond word SRAM_WORDS raises flash_valid with flash_addr equal to address bits 23..0. This includes the boot address 0x00100000.
- R5: A read in the flash window raises flash_valid with flash_addr equal to address bits 23..0. It returns flash_rdata when flash_ready is high.
- R6: A write (any strobe set) to the flash window, or to the scratchpad window at or beyond word SRAM_WORDS, is acknowledged in the same cycle. It raises no target select and leaves every scratchpad word unchanged.
- R7: In the register window, any word other than offsets 0x0, 0x4 and 0x8 is acknowledged in the same cycle and reads as zero.
- R8: cpu_ready is high only while cpu_valid is high, and only when the selected target is ready. The ready of a target that is not selected has no effect.
- R9: An access to the UART data word (offset 0x8) is held without ready for as long as dat_wait is high. It completes in the cycle dat_wait falls.
- R10: The flash configuration word (offset 0x0) raises cfg_sel and the UART divider word (offset 0x4) raises div_sel. The UART data word raises dat_sel. Each completes in the same cycle and returns its own read data. tgt_wdata and tgt_wstrb carry the CPU's write data and strobes.
- R11: While reset is asserted and after it is released with no request, cpu_ready and every target select are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Request complete |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_wstrb | input | 4 | Byte write strobes, all zero for a read |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| flash_valid | output | 1 | Read request to the flash controller |
| flash_ready | input | 1 | Flash read complete |
| flash_addr | output | 24 | Byte offset into flash |
| flash_rdata | input | 32 | Flash read data |
| cfg_sel | output | 1 | Flash configuration register selected |
| cfg_rdata | input | 32 | Flash configuration read value |
| div_sel | output | 1 | UART divider register selected |
| div_rdata | input | 32 | UART divider read value |
| dat_sel | output | 1 | UART data register selected |
| dat_wait | input | 1 | UART data access must wait |
| dat_rdata | input | 32 | UART data read value |
| tgt_wdata | output | 32 | Write data to register targets and the user port |
| tgt_wstrb | output | 4 | Write strobes to register targets and the user port |
| usr_valid | output | 1 | User-peripheral request |
| usr_ready | input | 1 | User-peripheral complete |
| usr_addr | output | 32 | User-peripheral byte address |
| usr_rdata | input | 32 | User-peripheral read data |

## Verification
The assertions check four rules in every cycle: at most one target select is active, ready never appears without a request, the UART data access stalls while dat_wait is high, and an unassigned register word answers at once with zero. They also check that the boot address is routed to flash, that a write into the flash window is dropped with an immediate ready, and that a scratchpad request completes one cycle later. Other behaviour shows only over a sequence of bus transfers, and the bench's scenarios cover it: read data matching the last write, the merging of byte strobes, a dropped write beyond the SRAM end that leaves the aliased low word unchanged, and the ready of a target that is not selected being ignored.

// File: rtl/soc_route_pkg.sv
package soc_route_pkg;

   typedef enum logic [2:0] {
      TGT_SRAM  = 3'd0,
      TGT_FLASH = 3'd1,
      TGT_CFG   = 3'd2,
      TGT_DIV   = 3'd3,
      TGT_DAT   = 3'd4,
      TGT_USER  = 3'd5,
      TGT_NONE  = 3'd6
   } route_tgt_e;

endpackage

// File: rtl/soc_route_decode.sv
module soc_route_decode
   import soc_route_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFF_LSB    = 2,
   parameter int WIN_AW     = 24,
   parameter int SRAM_WORDS = 256
) (
   input  logic [ADDR_W-OFF_LSB-1:0] word_addr,
   input  logic                      is_write,
   output route_tgt_e                tgt
);

   localparam int WIDX_W = WIN_AW - OFF_LSB;
   localparam int RGN_W  = ADDR_W - WIN_AW;

   localparam logic [RGN_W-1:0]  RGN_LOW   = RGN_W'(0);
   localparam logic [RGN_W-1:0]  RGN_FLASH = RGN_W'(1);
   localparam logic [RGN_W-1:0]  RGN_REGS  = RGN_W'(2);
   localparam logic [WIDX_W-1:0] SRAM_LIM  = WIDX_W'(SRAM_WORDS);
   localparam logic [WIDX_W-1:0] W_CFG     = WIDX_W'(0);
   localparam logic [WIDX_W-1:0] W_DIV     = WIDX_W'(1);
   localparam logic [WIDX_W-1:0] W_DAT     = WIDX_W'(2);

   logic [RGN_W-1:0]  region;
   logic [WIDX_W-1:0] idx;

   assign region = word_addr[ADDR_W-OFF_LSB-1:WIDX_W];
   assign idx    = word_addr[WIDX_W-1:0];

   always_comb begin
      tgt = TGT_USER;
      if (region == RGN_LOW) begin
         if (idx < SRAM_LIM)  tgt = TGT_SRAM;
         else if (is_write)   tgt = TGT_NONE;
         else                 tgt = TGT_FLASH;
      end else if (region == RGN_FLASH) begin
         tgt = is_write ? TGT_NONE : TGT_FLASH;
      end else if (region == RGN_REGS) begin
         if (idx == W_CFG)       tgt = TGT_CFG;
         else if (idx == W_DIV)  tgt = TGT_DIV;
         else if (idx == W_DAT)  tgt = TGT_DAT;
         else                    tgt = TGT_NONE;
      end
   end

endmodule

// File: rtl/soc_route_sram.sv
module soc_route_sram #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 256,
   parameter int AW     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [AW-1:0]       idx,
   input  logic [DATA_W/8-1:0] strb,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                ack
);

   localparam int LANES = DATA_W / 8;

   logic first;
   assign first = req && !ack;

   always_ff @(posedge clk) begin
      if (!rst_n) ack <= 1'b0;
      else        ack <= first;
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [7:0] lane_mem [WORDS];
      logic [7:0] lane_q;

      always_ff @(posedge clk) begin
         if (first) begin
            if (strb[ln]) lane_mem[idx] <= wdata[ln*8 +: 8];
            lane_q <= lane_mem[idx];
         end
      end

      assign rdata[ln*8 +: 8] = lane_q;
   end

endmodule

// File: rtl/soc_route_return.sv
module soc_route_return
   import soc_route_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  route_tgt_e        tgt,
   input  logic              valid,
   input  logic              sram_ack,
   input  logic [DATA_W-1:0] sram_rdata,
   input  logic              flash_ready,
   input  logic [DATA_W-1:0] flash_rdata,
   input  logic [DATA_W-1:0] cfg_rdata,
   input  logic [DATA_W-1:0] div_rdata,
   input  logic              dat_wait,
   input  logic [DATA_W-1:0] dat_rdata,
   input  logic              usr_ready,
   input  logic [DATA_W-1:0] usr_rdata,
   output logic              ready,
   output logic [DATA_W-1:0] rdata
);

   logic rdy_sel;

   always_comb begin
      rdy_sel = 1'b0;
      rdata   = '0;
      unique case (tgt)
         TGT_SRAM:  begin rdy_sel = sram_ack;    rdata = sram_rdata;  end
         TGT_FLASH: begin rdy_sel = flash_ready; rdata = flash_rdata; end
         TGT_CFG:   begin rdy_sel = 1'b1;        rdata = cfg_rdata;   end
         TGT_DIV:   begin rdy_sel = 1'b1;        rdata = div_rdata;   end
         TGT_DAT:   begin rdy_sel = !dat_wait;   rdata = dat_rdata;   end
         TGT_USER:  begin rdy_sel = usr_ready;   rdata = usr_rdata;   end
         default:   begin rdy_sel = 1'b1;        rdata = '0;          end
      endcase
   end

   assign ready = valid && rdy_sel;

endmodule

// File: rtl/soc_addr_router.sv
module soc_addr_router
   import soc_route_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int WIN_AW     = 24,
   parameter int SRAM_WORDS = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_valid,
   output logic                cpu_ready,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic [DATA_W/8-1:0] cpu_wstrb,
   output logic [DATA_W-1:0]   cpu_rdata,
   output logic                flash_valid,
   input  logic                flash_ready,
   output logic [WIN_AW-1:0]   flash_addr,
   input  logic [DATA_W-1:0]   flash_rdata,
   output logic                cfg_sel,
   input  logic [DATA_W-1:0]   cfg_rdata,
   output logic                div_sel,
   input  logic [DATA_W-1:0]   div_rdata,
   output logic                dat_sel,
   input  logic                dat_wait,
   input  logic [DATA_W-1:0]   dat_rdata,
   output logic [DATA_W-1:0]   tgt_wdata,
   output logic [DATA_W/8-1:0] tgt_wstrb,
   output logic                usr_valid,
   input  logic                usr_ready,
   output logic [ADDR_W-1:0]   usr_addr,
   input  logic [DATA_W-1:0]   usr_rdata
);

   localparam int STRB_W  = DATA_W / 8;
   localparam int OFF_LSB = $clog2(STRB_W);
   localparam int SRAM_AW = (SRAM_WORDS > 1) ? $clog2(SRAM_WORDS) : 1;
   localparam int RGN_W   = ADDR_W - WIN_AW;
   localparam logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(32'h0010_0000);
   localparam logic [RGN_W-1:0]  RGN_FLASH = RGN_W'(1);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (WIN_AW >= ADDR_W - 1 || WIN_AW <= OFF_LSB) begin : g_bad_win
      $error("WIN_AW must leave room for at least four regions");
   end
   if (SRAM_WORDS < 1 || SRAM_WORDS >= (1 << (WIN_AW - OFF_LSB))) begin : g_bad_sram
      $error("SRAM_WORDS must fit strictly inside the low window");
   end

   route_tgt_e          tgt;
   logic                is_write;
   logic                sram_req;
   logic                sram_ack;
   logic [DATA_W-1:0]   sram_rdata;

   assign is_write = |cpu_wstrb;

   soc_route_decode #(
      .ADDR_W     (ADDR_W),
      .OFF_LSB    (OFF_LSB),
      .WIN_AW     (WIN_AW),
      .SRAM_WORDS (SRAM_WORDS)
   ) i_decode (
      .word_addr (cpu_addr[ADDR_W-1:OFF_LSB]),
      .is_write  (is_write),
      .tgt       (tgt)
   );

   assign sram_req    = cpu_valid && (tgt == TGT_SRAM);
   assign flash_valid = cpu_valid && (tgt == TGT_FLASH);
   assign cfg_sel     = cpu_valid && (tgt == TGT_CFG);
   assign div_sel     = cpu_valid && (tgt == TGT_DIV);
   assign dat_sel     = cpu_valid && (tgt == TGT_DAT);
   assign usr_valid   = cpu_valid && (tgt == TGT_USER);

   assign flash_addr = cpu_addr[WIN_AW-1:0];
   assign usr_addr   = cpu_addr;
   assign tgt_wdata  = cpu_wdata;
   assign tgt_wstrb  = cpu_wstrb;

   soc_route_sram #(
      .DATA_W (DATA_W),
      .WORDS  (SRAM_WORDS),
      .AW     (SRAM_AW)
   ) i_sram (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (sram_req),
      .idx   (cpu_addr[OFF_LSB +: SRAM_AW]),
      .strb  (cpu_wstrb),
      .wdata (cpu_wdata),
      .rdata (sram_rdata),
      .ack   (sram_ack)
   );

   soc_route_return #(
      .DATA_W (DATA_W)
   ) i_return (
      .tgt         (tgt),
      .valid       (cpu_valid),
      .sram_ack    (sram_ack),
      .sram_rdata  (sram_rdata),
      .flash_ready (flash_ready),
      .flash_rdata (flash_rdata),
      .cfg_rdata   (cfg_rdata),
      .div_rdata   (div_rdata),
      .dat_wait    (dat_wait),
      .dat_rdata   (dat_rdata),
      .usr_ready   (usr_ready),
      .usr_rdata   (usr_rdata),
      .ready       (cpu_ready),
      .rdata       (cpu_rdata)
   );

   p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sram_req, flash_valid, cfg_sel, div_sel, dat_sel, usr_valid}));

   p_ready_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_valid);

   p_sram_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_req && !cpu_ready) |=> (cpu_ready || !cpu_valid));

   p_boot_to_flash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !is_write && cpu_addr[ADDR_W-1:OFF_LSB] == BOOT_ADDR[ADDR_W-1:OFF_LSB])
      |-> (flash_valid && flash_addr == BOOT_ADDR[WIN_AW-1:0]));

   p_write_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && is_write && cpu_addr[ADDR_W-1:WIN_AW] == RGN_FLASH)
      |-> (cpu_ready && !flash_valid && !sram_req));

   p_hole_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !is_write && tgt == TGT_NONE) |-> (cpu_ready && cpu_rdata == '0));

   p_dat_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_sel && dat_wait) |-> !cpu_ready);

endmodule

// File: tb/test_soc_addr_router.sv
module test_soc_addr_router;

   localparam int CLK_PERIOD = 10;
   localparam int SRAM_WORDS = 256;
   localparam logic [31:0] CFG_VAL = 32'h8008_0000;
   localparam logic [31:0] DIV_VAL = 32'h0000_0068;
   localparam logic [31:0] DAT_VAL = 32'h0000_00A7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_ready;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_wstrb = '0;
   logic [31:0] cpu_rdata;
   logic        flash_valid;
   logic        flash_ready = 1'b0;
   logic [23:0] flash_addr;
   logic [31:0] flash_rdata;
   logic        cfg_sel, div_sel, dat_sel, usr_valid;
   logic        dat_wait = 1'b0;
   logic [31:0] tgt_wdata;
   logic [3:0]  tgt_wstrb;
   logic        usr_ready;
   logic        usr_ready_m = 1'b0;
   logic        force_usr = 1'b0;
   logic [31:0] usr_addr;
   logic [31:0] usr_rdata;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int fcnt = 0;
   logic [31:0] mdl [SRAM_WORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] flash_word(input logic [23:0] a);
      return {a[9:2] ^ 8'hC3, a};
   endfunction

   assign flash_rdata = flash_word(flash_addr);
   assign usr_rdata   = ~usr_addr;
   assign usr_ready   = usr_ready_m | force_usr;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (flash_ready) begin
         flash_ready <= 1'b0;
         fcnt <= 0;
      end else if (flash_valid) begin
         if (fcnt == 2) flash_ready <= 1'b1;
         else           fcnt <= fcnt + 1;
      end
      usr_ready_m <= usr_valid && !usr_ready_m;
   end

   soc_addr_router i_soc_addr_router (
      .clk (clk), .rst_n (rst_n),
      .cpu_valid (cpu_valid), .cpu_ready (cpu_ready), .cpu_addr (cpu_addr),
      .cpu_wdata (cpu_wdata), .cpu_wstrb (cpu_wstrb), .cpu_rdata (cpu_rdata),
      .flash_valid (flash_valid), .flash_ready (flash_ready),
      .flash_addr (flash_addr), .flash_rdata (flash_rdata),
      .cfg_sel (cfg_sel), .cfg_rdata (CFG_VAL),
      .div_sel (div_sel), .div_rdata (DIV_VAL),
      .dat_sel (dat_sel), .dat_wait (dat_wait), .dat_rdata (DAT_VAL),
      .tgt_wdata (tgt_wdata), .tgt_wstrb (tgt_wstrb),
      .usr_valid (usr_valid), .usr_ready (usr_ready),
      .usr_addr (usr_addr), .usr_rdata (usr_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // target kinds: 0 sram, 1 flash, 2 cfg, 3 div, 4 dat, 5 user, 6 dropped/none
   function automatic int exp_kind(input logic [31:0] a, input logic [3:0] s);
      logic wr = |s;
      if (a[31:24] == 8'h00) return (a[23:2] < SRAM_WORDS) ? 0 : (wr ? 6 : 1);
      if (a[31:24] == 8'h01) return wr ? 6 : 1;
      if (a[31:24] == 8'h02) begin
         if (a[23:2] == 0) return 2;
         if (a[23:2] == 1) return 3;
         if (a[23:2] == 2) return 4;
         return 6;
      end
      return 5;
   endfunction

   function automatic logic [4:0] exp_mask(input int k);
      case (k)
         1: return 5'b00001;
         5: return 5'b00010;
         2: return 5'b00100;
         3: return 5'b01000;
         4: return 5'b10000;
         default: return 5'b00000;
      endcase
   endfunction

   task automatic xfer(input logic [31:0] a, input logic [3:0] s, input logic [31:0] wd,
                       output logic [31:0] rd, output int lat, output logic [4:0] mask,
                       output logic [23:0] fa, output logic wd_ok);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_addr = a; cpu_wstrb = s; cpu_wdata = wd;
      lat = 0; mask = '0; fa = '0; rd = '0; wd_ok = 1'b1;
      #1;
      for (int n = 0; n < 64; n++) begin
         mask |= {dat_sel, div_sel, cfg_sel, usr_valid, flash_valid};
         if (flash_valid) fa = flash_addr;
         if (tgt_wdata != wd || tgt_wstrb != s) wd_ok = 1'b0;
         if (cpu_ready) break;
         @(negedge clk); #1;
         lat++;
      end
      rd = cpu_rdata;
      if (!cpu_ready) chk(1'b0, "R8 transfer hung", a, 32'h0);
      @(negedge clk);
      cpu_valid = 1'b0; cpu_wstrb = '0;
   endtask

   task automatic run_one(input logic [31:0] a, input logic [3:0] s, input logic [31:0] wd);
      int k, lat;
      logic [31:0] rd, exp;
      logic [4:0] mask;
      logic [23:0] fa;
      logic wd_ok;
      string tag;
      k = exp_kind(a, s);
      xfer(a, s, wd, rd, lat, mask, fa, wd_ok);
      chk(mask == exp_mask(k), (k == 6) ? "R6 select" : "R1 select", {27'b0, mask}, {27'b0, exp_mask(k)});
      case (k)
         0: begin
            chk(lat == 1, "R2 latency", lat, 1);
            if (s == 0) chk(rd == mdl[a[9:2]], "R2 read", rd, mdl[a[9:2]]);
            for (int b = 0; b < 4; b++) if (s[b]) mdl[a[9:2]][b*8 +: 8] = wd[b*8 +: 8];
         end
         1: begin
            tag = (a[31:24] == 8'h00) ? "R4" : "R5";
            chk(fa == a[23:0], {tag, " flash addr"}, {8'h0, fa}, {8'h0, a[23:0]});
            chk(rd == flash_word(a[23:0]), {tag, " flash data"}, rd, flash_word(a[23:0]));
         end
         2, 3, 4: begin
            exp = (k == 2) ? CFG_VAL : (k == 3) ? DIV_VAL : DAT_VAL;
            chk(lat == 0, "R10 latency", lat, 0);
            chk(wd_ok, "R10 write pass", tgt_wdata, wd);
            if (s == 0) chk(rd == exp, "R10 read", rd, exp);
         end
         5: begin
            chk(wd_ok, "R1 user write pass", tgt_wdata, wd);
            if (s == 0) chk(rd == ~a, "R1 user read", rd, ~a);
         end
         default: begin
            chk(lat == 0, (s != 0) ? "R6 latency" : "R7 latency", lat, 0);
            if (s == 0) chk(rd == 0, "R7 zero", rd, 0);
         end
      endcase
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "watchdog", cycles, 0);
      finish_run();
   end

   initial begin
      logic [31:0] rd, a;
      int lat;
      logic [4:0] mask;
      logic [23:0] fa;
      logic wd_ok;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      #1;
      chk(!cpu_ready && !flash_valid && !usr_valid && !cfg_sel, "R11 in reset", cpu_ready, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!cpu_ready && !flash_valid && !usr_valid && !cfg_sel && !div_sel && !dat_sel,
          "R11 after reset", cpu_ready, 0);

      for (int w = 0; w < SRAM_WORDS; w++) run_one(w * 4, 4'hF, 32'h5000_0000 + w * 32'h0101_0001);

      // R3 byte strobe merge
      run_one(32'h14, 4'hF, 32'h1122_3344);
      run_one(32'h14, 4'b1010, 32'hAABB_CCDD);
      xfer(32'h14, 4'h0, 0, rd, lat, mask, fa, wd_ok);
      chk(rd == 32'hAA22_CC44, "R3 strobe merge", rd, 32'hAA22_CC44);

      // R4 boot address
      run_one(32'h0010_0000, 4'h0, 0);

      // R6 write beyond SRAM end must not alias word 0
      run_one(SRAM_WORDS * 4, 4'hF, 32'hDEAD_BEEF);
      run_one(32'h0100_0000, 4'hF, 32'hDEAD_BEEF);
      xfer(32'h0, 4'h0, 0, rd, lat, mask, fa, wd_ok);
      chk(rd == mdl[0], "R6 sram word 0 untouched", rd, mdl[0]);

      // R7 hole words at the edges of the register window
      run_one(32'h0200_000C, 4'h0, 0);
      run_one(32'h02FF_FFFC, 4'h0, 0);

      // R8 unselected ready ignored
      force_usr = 1'b1;
      xfer(32'h20, 4'h0, 0, rd, lat, mask, fa, wd_ok);
      chk(lat == 1, "R8 foreign ready ignored", lat, 1);
      force_usr = 1'b0;

      // R9 stall on UART data word
      dat_wait = 1'b1;
      @(negedge clk);
      cpu_valid = 1'b1; cpu_addr = 32'h0200_0008; cpu_wstrb = 4'h0;
      for (int n = 0; n < 3; n++) begin
         #1;
         chk(dat_sel && !cpu_ready, "R9 stall", cpu_ready, 0);
         @(negedge clk);
      end
      dat_wait = 1'b0;
      #1;
      chk(cpu_ready && cpu_rdata == DAT_VAL, "R9 release", cpu_rdata, DAT_VAL);
      @(negedge clk);
      cpu_valid = 1'b0;

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int r;
         logic [3:0] s;
         r = $urandom % 6;
         case (r)
            0: a = ($urandom % SRAM_WORDS) * 4;
            1: a = (SRAM_WORDS + $urandom % ((1 << 22) - SRAM_WORDS)) * 4;
            2: a = 32'h0100_0000 | ($urandom & 32'h00FF_FFFC);
            3: begin
               int w = $urandom % 4;
               a = (w < 3) ? 32'h0200_0000 + w * 4
                           : 32'h0200_0000 + (3 + $urandom % ((1 << 22) - 3)) * 4;
            end
            4: a = 32'h0300_0000 + (($urandom % 32'hFD00_0000) & 32'hFFFF_FFFC);
            default: a = 32'h0010_0000;
         endcase
         s = (($urandom % 2) == 0 || r == 5) ? 4'h0 : 4'(1 + $urandom % 15);
         run_one(a, s, $urandom);
      end

      finish_run();
   end

endmodule